// File: doc/BRIEF.md
# Convolution Layer Sequencing Controller

This controller runs one convolution layer at a time on a single shared compute core. A new-layer request latches the layer geometry (input side, kernel side, padding, stride). The controller then reads every kernel weight from an external memory port into an on-chip weight buffer. The buffer drives the core and does not change for the rest of the layer.

The controller then moves the kernel window across the padded input in row-major order. At each window position it does four things in turn. It asks the input stager to fetch and convert the receptive field. It fires the core for exactly one cycle, which produces the results of all kernels at once. It accepts the digitised results from the converter. It writes them back to external memory at the index of the window position. After the last write is acknowledged it pulses a done strobe and returns to idle, ready for the next layer. Layer time therefore depends on the number of window positions and not on the number of kernels.

The number of kernels and channels and the size of the weight buffer are fixed by parameters. The geometry is given at run time and is held for the whole layer.

Top module: `conv_layer_seq`

## Requirements
- R1: While reset is active and until the first request, busy, done, core fire and every valid and ready output the controller drives are low.
- R2: A request on start_i is accepted only when the controller is idle, and the geometry inputs are sampled in that cycle. A request in any other cycle is ignored, including the cycle in which done is high. Changes on the geometry inputs during a layer have no effect.
- R3: After acceptance, the controller issues weight reads for addresses 0 up to K*NC*m*m-1 in rising order. Each read holds its valid and address until ready. The word returned with address a lands in slot a of weights_o, which is bits a*WW upward.
- R4: weights_o changes only on a weight-read handshake. From the end of the weight load until the next layer's load, it holds every loaded slot unchanged.
- R5: A layer visits (floor((n+2p-m)/s)+1)^2 window positions. Position index i is at padded row (i div L)*s and padded column (i mod L)*s, where L=floor((n+2p-m)/s)+1.
- R6: At each position the controller holds the stage request until it is acknowledged. It fires the core in the next cycle, raises result ready in the cycle after that and holds it until results are valid, then raises the store request. Only one of these strobes is active in any cycle.
- R7: core_fire_o is high for exactly one cycle per window position.
- R8: The store request carries the position index as address and the captured results of all K kernels as data. It holds both stable until acknowledged.
- R9: done_o pulses for one cycle, in the cycle after the last store is acknowledged. The controller is idle in the next cycle.
- R10: busy_o is high from the cycle after a request is accepted through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | New-layer request |
| cfg_n_i | input | 6 | Input feature map side |
| cfg_m_i | input | 6 | Kernel side |
| cfg_p_i | input | 6 | Padding |
| cfg_s_i | input | 6 | Stride |
| busy_o | output | 1 | Layer in progress |
| wt_rd_valid_o | output | 1 | Weight read request |
| wt_rd_addr_o | output | 7 | Weight read address |
| wt_rd_ready_i | input | 1 | Weight read completes; data valid |
| wt_rd_data_i | input | 8 | Weight word |
| weights_o | output | 576 | Weight buffer contents to the core |
| stg_valid_o | output | 1 | Stage-inputs request |
| stg_row_o | output | 8 | Window row in padded coordinates |
| stg_col_o | output | 8 | Window column in padded coordinates |
| stg_ready_i | input | 1 | Inputs staged and converted |
| core_fire_o | output | 1 | One-cycle compute strobe |
| res_valid_i | input | 1 | Digitised results available |
| res_data_i | input | 48 | Results of all kernels |
| res_ready_o | output | 1 | Controller takes results |
| st_valid_o | output | 1 | Store request |
| st_addr_o | output | 16 | Store address (position index) |
| st_data_o | output | 48 | Store data |
| st_ready_i | input | 1 | Store acknowledged |
| done_o | output | 1 | Layer complete pulse |

## Verification
Two events can fall in the same cycle: the done pulse of one layer and the request for the next. The bench holds start_i high from the done cycle onward with new geometry. It expects the request to be ignored in the done cycle and accepted in the idle cycle that follows, with the new layer's first weight read one cycle later. The bench also pulses start_i at random and drives random geometry throughout each layer. It judges that neither the number of stores nor the window coordinates move away from the values computed from the latched geometry.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LOADW,
    S_STAGE,
    S_FIRE,
    S_CAPT,
    S_STORE,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm
  import conv_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       wt_hs_i,
  input  logic       wt_last_i,
  input  logic       stg_hs_i,
  input  logic       res_hs_i,
  input  logic       st_hs_i,
  input  logic       loc_last_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i)                state_d = S_LOADW;
      S_LOADW: if (wt_hs_i && wt_last_i)   state_d = S_STAGE;
      S_STAGE: if (stg_hs_i)               state_d = S_FIRE;
      S_FIRE:                              state_d = S_CAPT;
      S_CAPT:  if (res_hs_i)               state_d = S_STORE;
      S_STORE: if (st_hs_i)                state_d = loc_last_i ? S_DONE : S_STAGE;
      S_DONE:                              state_d = S_IDLE;
      default:                             state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/conv_seq_loc.sv
module conv_seq_loc #(
  parameter int GW  = 6,
  parameter int PW  = GW + 2,
  parameter int LAW = 2 * PW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic           adv_i,
  input  logic [GW-1:0]  cfg_n_i,
  input  logic [GW-1:0]  cfg_m_i,
  input  logic [GW-1:0]  cfg_p_i,
  input  logic [GW-1:0]  cfg_s_i,
  output logic [PW-1:0]  row_o,
  output logic [PW-1:0]  col_o,
  output logic [LAW-1:0] idx_o,
  output logic           last_o
);
  logic [PW-1:0]  span_q, m_q, s_q, row_q, col_q;
  logic [LAW-1:0] idx_q;
  logic [PW:0]    col_reach, row_reach;
  logic           col_end, row_end;

  // window fits while position + stride + kernel stays inside the padded span
  always_comb begin
    col_reach = {1'b0, col_q} + {1'b0, s_q} + {1'b0, m_q};
    row_reach = {1'b0, row_q} + {1'b0, s_q} + {1'b0, m_q};
    col_end   = col_reach > {1'b0, span_q};
    row_end   = row_reach > {1'b0, span_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_q <= '0;
      m_q    <= '0;
      s_q    <= '0;
      row_q  <= '0;
      col_q  <= '0;
      idx_q  <= '0;
    end else if (init_i) begin
      span_q <= PW'(cfg_n_i) + (PW'(cfg_p_i) << 1);
      m_q    <= PW'(cfg_m_i);
      s_q    <= PW'(cfg_s_i);
      row_q  <= '0;
      col_q  <= '0;
      idx_q  <= '0;
    end else if (adv_i) begin
      idx_q <= idx_q + LAW'(1);
      if (col_end) begin
        col_q <= '0;
        row_q <= row_q + s_q;
      end else begin
        col_q <= col_q + s_q;
      end
    end
  end

  assign row_o  = row_q;
  assign col_o  = col_q;
  assign idx_o  = idx_q;
  assign last_o = col_end && row_end;
endmodule

// File: rtl/conv_seq_wbuf.sv
module conv_seq_wbuf #(
  parameter int KNC = 8,
  parameter int NW  = 72,
  parameter int WW  = 8,
  parameter int GW  = 6,
  parameter int AW  = $clog2(NW),
  parameter int TW  = AW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_i,
  input  logic [GW-1:0]  cfg_m_i,
  input  logic           wr_i,
  input  logic [WW-1:0]  wr_data_i,
  output logic [AW-1:0]  addr_o,
  output logic           last_o,
  output logic [NW*WW-1:0] weights_o
);
  logic [AW-1:0] addr_q;
  logic [TW-1:0] wtot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wtot_q <= '0;
    end else if (init_i) begin
      addr_q <= '0;
      wtot_q <= TW'(KNC) * TW'(cfg_m_i) * TW'(cfg_m_i);
    end else if (wr_i) begin
      addr_q <= addr_q + AW'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = ({1'b0, addr_q} == (wtot_q - TW'(1)));

  for (genvar i = 0; i < NW; i++) begin : g_slot
    logic [WW-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (wr_i && (addr_q == AW'(i))) slot_q <= wr_data_i;
    end
    assign weights_o[i*WW +: WW] = slot_q;
  end
endmodule

// File: rtl/conv_layer_seq.sv
module conv_layer_seq
  import conv_seq_pkg::*;
#(
  parameter int K     = 4,
  parameter int NC    = 2,
  parameter int MAX_M = 3,
  parameter int GW    = 6,
  parameter int WW    = 8,
  parameter int RW    = 12,
  localparam int NWT  = K * NC * MAX_M * MAX_M,
  localparam int WAW  = $clog2(NWT),
  localparam int PW   = GW + 2,
  localparam int LAW  = 2 * PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [GW-1:0]     cfg_n_i,
  input  logic [GW-1:0]     cfg_m_i,
  input  logic [GW-1:0]     cfg_p_i,
  input  logic [GW-1:0]     cfg_s_i,
  output logic              busy_o,
  output logic              wt_rd_valid_o,
  output logic [WAW-1:0]    wt_rd_addr_o,
  input  logic              wt_rd_ready_i,
  input  logic [WW-1:0]     wt_rd_data_i,
  output logic [NWT*WW-1:0] weights_o,
  output logic              stg_valid_o,
  output logic [PW-1:0]     stg_row_o,
  output logic [PW-1:0]     stg_col_o,
  input  logic              stg_ready_i,
  output logic              core_fire_o,
  input  logic              res_valid_i,
  input  logic [K*RW-1:0]   res_data_i,
  output logic              res_ready_o,
  output logic              st_valid_o,
  output logic [LAW-1:0]    st_addr_o,
  output logic [K*RW-1:0]   st_data_o,
  input  logic              st_ready_i,
  output logic              done_o
);
  logic [1:0]     rst_sync_q;
  logic           rst_sync_n;
  seq_state_e     state;
  logic           start_take, wt_hs, stg_hs, res_hs, st_hs;
  logic           wt_last, loc_last, loc_adv;
  logic [K*RW-1:0] res_q;

  // reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign start_take = (state == S_IDLE) && start_i;
  assign wt_hs      = wt_rd_valid_o && wt_rd_ready_i;
  assign stg_hs     = stg_valid_o && stg_ready_i;
  assign res_hs     = res_ready_o && res_valid_i;
  assign st_hs      = st_valid_o && st_ready_i;
  assign loc_adv    = st_hs && !loc_last;

  conv_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .wt_hs_i    (wt_hs),
    .wt_last_i  (wt_last),
    .stg_hs_i   (stg_hs),
    .res_hs_i   (res_hs),
    .st_hs_i    (st_hs),
    .loc_last_i (loc_last),
    .state_o    (state)
  );

  conv_seq_loc #(.GW(GW), .PW(PW), .LAW(LAW)) u_loc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .init_i  (start_take),
    .adv_i   (loc_adv),
    .cfg_n_i (cfg_n_i),
    .cfg_m_i (cfg_m_i),
    .cfg_p_i (cfg_p_i),
    .cfg_s_i (cfg_s_i),
    .row_o   (stg_row_o),
    .col_o   (stg_col_o),
    .idx_o   (st_addr_o),
    .last_o  (loc_last)
  );

  conv_seq_wbuf #(.KNC(K*NC), .NW(NWT), .WW(WW), .GW(GW), .AW(WAW)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .init_i    (start_take),
    .cfg_m_i   (cfg_m_i),
    .wr_i      (wt_hs),
    .wr_data_i (wt_rd_data_i),
    .addr_o    (wt_rd_addr_o),
    .last_o    (wt_last),
    .weights_o (weights_o)
  );

  always_ff @(posedge clk) begin
    if (res_hs) res_q <= res_data_i;
  end

  assign busy_o        = (state != S_IDLE);
  assign wt_rd_valid_o = (state == S_LOADW);
  assign stg_valid_o   = (state == S_STAGE);
  assign core_fire_o   = (state == S_FIRE);
  assign res_ready_o   = (state == S_CAPT);
  assign st_valid_o    = (state == S_STORE);
  assign done_o        = (state == S_DONE);
  assign st_data_o     = res_q;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int WBW = 576,
  parameter int PW  = 8,
  parameter int LAW = 16,
  parameter int DW  = 48
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_i,
  input logic           busy_o,
  input logic           wt_rd_valid_o,
  input logic           wt_rd_ready_i,
  input logic [WBW-1:0] weights_o,
  input logic           stg_valid_o,
  input logic           stg_ready_i,
  input logic [PW-1:0]  stg_row_o,
  input logic [PW-1:0]  stg_col_o,
  input logic           core_fire_o,
  input logic           res_ready_o,
  input logic           st_valid_o,
  input logic           st_ready_i,
  input logic [LAW-1:0] st_addr_o,
  input logic [DW-1:0]  st_data_o,
  input logic           done_o
);
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wt_rd_valid_o, stg_valid_o, core_fire_o, res_ready_o, st_valid_o, done_o}));

  p_fire_after_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid_o && stg_ready_i) |=> core_fire_o);

  p_capt_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_fire_o |=> res_ready_o);

  p_stage_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stg_valid_o && !stg_ready_i) |=> (stg_valid_o && $stable(stg_row_o) && $stable(stg_col_o)));

  p_fire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    core_fire_o |=> !core_fire_o);

  p_weights_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wt_rd_valid_o && wt_rd_ready_i) |=> $stable(weights_o));

  p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid_o && !st_ready_i) |=> (st_valid_o && $stable(st_addr_o) && $stable(st_data_o)));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  p_start_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && wt_rd_valid_o));
endmodule

bind conv_layer_seq conv_seq_chk #(
  .WBW (NWT * WW),
  .PW  (PW),
  .LAW (LAW),
  .DW  (K * RW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .start_i       (start_i),
  .busy_o        (busy_o),
  .wt_rd_valid_o (wt_rd_valid_o),
  .wt_rd_ready_i (wt_rd_ready_i),
  .weights_o     (weights_o),
  .stg_valid_o   (stg_valid_o),
  .stg_ready_i   (stg_ready_i),
  .stg_row_o     (stg_row_o),
  .stg_col_o     (stg_col_o),
  .core_fire_o   (core_fire_o),
  .res_ready_o   (res_ready_o),
  .st_valid_o    (st_valid_o),
  .st_ready_i    (st_ready_i),
  .st_addr_o     (st_addr_o),
  .st_data_o     (st_data_o),
  .done_o        (done_o)
);

// File: tb/conv_layer_seq_bench.sv
module conv_layer_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int K     = 4;
  localparam int NC    = 2;
  localparam int MAX_M = 3;
  localparam int GW    = 6;
  localparam int WW    = 8;
  localparam int RW    = 12;
  localparam int NWT   = K * NC * MAX_M * MAX_M;
  localparam int WAW   = $clog2(NWT);
  localparam int PW    = GW + 2;
  localparam int LAW   = 2 * PW;
  localparam int NL    = 5;

  logic clk, rst_n, start_i;
  logic [GW-1:0] cfg_n_i, cfg_m_i, cfg_p_i, cfg_s_i;
  logic busy_o, wt_rd_valid_o, wt_rd_ready_i;
  logic [WAW-1:0] wt_rd_addr_o;
  logic [WW-1:0] wt_rd_data_i;
  logic [NWT*WW-1:0] weights_o;
  logic stg_valid_o, stg_ready_i, core_fire_o, res_valid_i, res_ready_o;
  logic [PW-1:0] stg_row_o, stg_col_o;
  logic [K*RW-1:0] res_data_i, st_data_o;
  logic st_valid_o, st_ready_i, done_o;
  logic [LAW-1:0] st_addr_o;

  conv_layer_seq u_conv_layer_seq (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int ln[NL] = '{4, 5, 6, 3, 7};
  int lm[NL] = '{2, 3, 3, 3, 1};
  int lp[NL] = '{0, 1, 0, 0, 0};
  int ls[NL] = '{1, 2, 3, 1, 2};

  logic [WW-1:0]   wexp [NWT];
  logic [K*RW-1:0] res_exp;
  int mph, li, wcnt, wtot, locs_side, idx, nstore, cyc, tail, m_cur;
  bit  wbad;

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    cfg_n_i = '0; cfg_m_i = '0; cfg_p_i = '0; cfg_s_i = '0;
    wt_rd_ready_i = 1'b0; wt_rd_data_i = '0; stg_ready_i = 1'b0;
    res_valid_i = 1'b0; res_data_i = '0; st_ready_i = 1'b0;
    mph = 0; li = 0; wcnt = 0; wtot = 0; locs_side = 0; idx = 0; nstore = 0;
    cyc = 0; tail = 0; m_cur = 0; res_exp = '0;
    repeat (3) @(negedge clk);
    // R1: idle outputs under reset
    chk(!busy_o && !done_o && !core_fire_o, "R1", {busy_o, done_o, core_fire_o}, 0);
    chk(!wt_rd_valid_o && !stg_valid_o && !res_ready_o && !st_valid_o, "R1",
        {wt_rd_valid_o, stg_valid_o, res_ready_o, st_valid_o}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !wt_rd_valid_o, "R1", {busy_o, wt_rd_valid_o}, 0);

    while (li < NL || mph != 0 || tail < 4) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog expired at cycle %0d (R9) actual=busy expected=done", cyc);
        break;
      end
      if (li == NL && mph == 0) tail++;
      // ---- compare outputs with the model state ----
      chk(busy_o == (mph != 0), "R10 busy", busy_o, mph != 0);
      chk(wt_rd_valid_o == (mph == 1), "R3 wt valid", wt_rd_valid_o, mph == 1);
      if (mph == 1) chk(wt_rd_addr_o == WAW'(wcnt), "R3 wt addr", wt_rd_addr_o, wcnt);
      chk(stg_valid_o == (mph == 2), "R6 stage valid", stg_valid_o, mph == 2);
      if (mph == 2) begin
        chk(stg_row_o == PW'((idx / locs_side) * ls[li-1]), "R5 row", stg_row_o,
            (idx / locs_side) * ls[li-1]);
        chk(stg_col_o == PW'((idx % locs_side) * ls[li-1]), "R5 col", stg_col_o,
            (idx % locs_side) * ls[li-1]);
      end
      chk(core_fire_o == (mph == 3), "R7 fire", core_fire_o, mph == 3);
      chk(res_ready_o == (mph == 4), "R6 res ready", res_ready_o, mph == 4);
      chk(st_valid_o == (mph == 5), "R6 store valid", st_valid_o, mph == 5);
      if (mph == 5) begin
        chk(st_addr_o == LAW'(idx), "R8 store addr", st_addr_o, idx);
        chk(st_data_o == res_exp, "R8 store data", st_data_o, res_exp);
      end
      chk(done_o == (mph == 6), "R9 done", done_o, mph == 6);
      if (mph == 6) chk(nstore == locs_side * locs_side, "R5 store count", nstore,
                        locs_side * locs_side);
      if (mph >= 2) begin
        wbad = 1'b0;
        for (int a = 0; a < wtot; a++)
          if (weights_o[a*WW +: WW] != wexp[a]) wbad = 1'b1;
        chk(!wbad, "R4 weights held", wbad, 0);
      end
      // ---- drive inputs ----
      if ((mph == 0 || mph == 6) && li < NL) begin
        // R2: held across the done cycle; only the idle cycle may accept it
        start_i = 1'b1;
        cfg_n_i = GW'(ln[li]); cfg_m_i = GW'(lm[li]);
        cfg_p_i = GW'(lp[li]); cfg_s_i = GW'(ls[li]);
      end else if (mph != 0 && mph != 6) begin
        // R2: stray requests and geometry noise during the layer
        start_i = ($urandom % 3) == 0;
        cfg_n_i = GW'($urandom); cfg_m_i = GW'($urandom);
        cfg_p_i = GW'($urandom); cfg_s_i = GW'($urandom);
      end else begin
        start_i = 1'b0;
      end
      wt_rd_ready_i = $urandom % 2;
      wt_rd_data_i  = WW'($urandom);
      stg_ready_i   = ($urandom % 3) != 0;
      res_valid_i   = $urandom % 2;
      res_data_i    = (K*RW)'({$urandom, $urandom});
      st_ready_i    = $urandom % 2;
      // ---- advance the model ----
      case (mph)
        0: if (start_i) begin
             m_cur = lm[li];
             wtot = K * NC * m_cur * m_cur;
             locs_side = (ln[li] + 2 * lp[li] - m_cur) / ls[li] + 1;
             wcnt = 0; idx = 0; nstore = 0;
             li++;
             mph = 1;
           end
        1: if (wt_rd_ready_i) begin
             wexp[wcnt] = wt_rd_data_i;
             wcnt++;
             if (wcnt == wtot) mph = 2;
           end
        2: if (stg_ready_i) mph = 3;
        3: mph = 4;
        4: if (res_valid_i) begin
             res_exp = res_data_i;
             mph = 5;
           end
        5: if (st_ready_i) begin
             nstore++;
             if (idx == locs_side * locs_side - 1) mph = 6;
             else begin idx++; mph = 2; end
           end
        default: mph = 0;
      endcase
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule